// File: doc/BRIEF.md
# CPU Wait and Refresh Generator

This block drives the active-low wait input of an 8-bit processor whose memory cycles are marked by an opcode-fetch strobe and a memory-request strobe. A two-bit mode input picks when a single synchronous wait clock is added to a memory cycle. The choices are:

- on opcode fetches only;
- on every memory access;
- never.

Two bus ready lines can each hold the processor in a wait for any length of time.

While the processor is held by a ready line, it stops issuing its own DRAM refresh cycles. The block then times the stall. After a programmable number of clocks, it raises a refresh strobe for the DRAM array's pin-1 refresh input, and it keeps the wait output low for the whole pulse. The pulses repeat at a fixed spacing for as long as the stall lasts. A pulse that has started always runs to its end, even if the stall ends first. All outputs are registered on the rising edge of the clock, so a wait request is settled well before the processor samples it on the following falling edge.

Top module: `cpu_stall_refresh`

## Requirements
- R1: With `mode` = 2'b01, a memory cycle adds a wait only when `m1_n` is low together with `mreq_n`. A plain memory access, or `m1_n` low alone, adds none.
- R2: With `mode` = 2'b10, every memory cycle adds a wait, whether or not it is an opcode fetch.
- R3: With `mode` = 2'b00 or 2'b11, memory cycles add no wait.
- R4: A memory-cycle wait lasts exactly one clock. `wait_n` is low in the clock that follows the first rising edge at which `mreq_n` is seen low after being high, and it is high again in the clock after that, even while `mreq_n` stays low.
- R5: While `rdy` or `xrdy` is low, `wait_n` is low. This starts in the clock after the first edge that sees the line low, and it lasts one clock per clock that the line was held low.
- R6: Counting k = 0 as the first clock of a ready-line stall, refresh pulses begin at k = INTERVAL + m·(INTERVAL + PULSE) for m = 0, 1, 2, …. A pulse begins only if that start point is at most the stall length.
- R7: Each refresh pulse keeps `rfsh_strobe` high for exactly PULSE clocks, and `wait_n` stays low throughout. The pulse completes even when the stall ends before it does.
- R8: The stall interval count clears whenever the processor is not held by a ready line. Two stalls shorter than INTERVAL, separated by a ready clock, produce no refresh.
- R9: While `rst_n` is low, `wait_n` is high and `rfsh_strobe` is low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_n | input | 1 | Opcode-fetch cycle marker, active low |
| mreq_n | input | 1 | Memory request, active low |
| rdy | input | 1 | Bus ready line, low holds the processor |
| xrdy | input | 1 | Second bus ready line, low holds the processor |
| mode | input | 2 | Memory wait mode: 01 fetch only, 10 every access, 00/11 none |
| wait_n | output | 1 | Wait request to the processor, active low |
| rfsh_strobe | output | 1 | Pin-1 refresh pulse to the DRAM array |

## Verification
A stale or mis-cleared interval count moves a refresh pulse start by at least one clock. A wrong pulse counter lengthens or shortens `rfsh_strobe`. Either fault shows on the very clock where the arithmetic start or end point is expected. The bench sweeps every stall length from one clock up to beyond three refresh periods and compares both outputs on each clock, so an error in the count is visible within one refresh period of the stall start. A wrong edge detector for the memory request shows as a wait that is missing, doubled or present in the wrong mode within two clocks of the request.

// File: rtl/cpu_stall_refresh.sv
module cpu_stall_refresh #(
  parameter int INTERVAL = 120,
  parameter int PULSE    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       m1_n,
  input  logic       mreq_n,
  input  logic       rdy,
  input  logic       xrdy,
  input  logic [1:0] mode,
  output logic       wait_n,
  output logic       rfsh_strobe
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int PW = $clog2(PULSE + 1);
  localparam logic [CW-1:0] ILAST = CW'(INTERVAL - 1);
  localparam logic [PW-1:0] PLAST = PW'(PULSE - 1);

  logic          mreq_prev, mem_wait_q, ext_q, rf_q;
  logic [CW-1:0] icnt;
  logic [PW-1:0] pcnt;

  wire mem_start = !mreq_n && mreq_prev;
  wire mem_pick  = (mode == 2'b01 && !m1_n) || (mode == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreq_prev  <= 1'b1;
      mem_wait_q <= 1'b0;
      ext_q      <= 1'b0;
    end else begin
      mreq_prev  <= mreq_n;
      mem_wait_q <= mem_start && mem_pick;
      ext_q      <= !rdy || !xrdy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q <= 1'b0;
      icnt <= '0;
      pcnt <= '0;
    end else if (rf_q) begin
      if (pcnt == PLAST) rf_q <= 1'b0;
      else               pcnt <= pcnt + 1'b1;
    end else if (ext_q) begin
      if (icnt == ILAST) begin
        rf_q <= 1'b1;
        pcnt <= '0;
        icnt <= '0;
      end else begin
        icnt <= icnt + 1'b1;
      end
    end else begin
      icnt <= '0;
    end
  end

  assign wait_n      = !(mem_wait_q || ext_q || rf_q);
  assign rfsh_strobe = rf_q;
endmodule

module cpu_stall_refresh_chk #(
  parameter int PULSE = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy,
  input logic       xrdy,
  input logic [1:0] mode,
  input logic       wait_n,
  input logic       rfsh_strobe
);
  logic [15:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= rfsh_strobe ? run_len + 16'd1 : 16'd0;
  end

  a_r9_reset_idle: assert property (@(posedge clk) !rst_n |-> (wait_n && !rfsh_strobe));
  a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy || !xrdy) |=> !wait_n);
  a_r7_wait_in_rfsh: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_strobe |-> !wait_n);
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_strobe) |-> run_len == 16'(PULSE));
  a_r6_only_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_strobe) |-> $past(!wait_n));
  a_r3_no_mem_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b00 || mode == 2'b11) && rdy && xrdy) |=> (wait_n || rfsh_strobe));
endmodule

bind cpu_stall_refresh cpu_stall_refresh_chk #(.PULSE(PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .xrdy(xrdy), .mode(mode),
  .wait_n(wait_n), .rfsh_strobe(rfsh_strobe)
);

// File: tb/cpu_stall_refresh_bench.sv
module cpu_stall_refresh_bench;
  localparam int CLK_PERIOD = 10;
  localparam int I = 5;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0, m1_n = 1'b1, mreq_n = 1'b1, rdy = 1'b1, xrdy = 1'b1;
  logic [1:0] mode = 2'b00;
  logic wait_n, rfsh_strobe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_stall_refresh #(.INTERVAL(I), .PULSE(P)) u_cpu_stall_refresh (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n), .rdy(rdy), .xrdy(xrdy),
    .mode(mode), .wait_n(wait_n), .rfsh_strobe(rfsh_strobe));

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  function automatic bit exp_rf(int k, int len);
    for (int m = 0; m < 8; m++) begin
      int s = I + m * (I + P);
      if (s <= len && k >= s && k < s + P) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic mem_cycle(logic [1:0] md, logic fetch, logic exp_wait);
    string tag;
    tag = (md == 2'b01) ? "R1" : (md == 2'b10) ? "R2" : "R3";
    @(negedge clk);
    mode = md; m1_n = !fetch; mreq_n = 1'b0;
    @(negedge clk);
    check(tag, wait_n, !exp_wait);
    @(negedge clk);
    check("R4", wait_n, 1'b1);
    mreq_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);
    check("R4", wait_n, 1'b1);
  endtask

  task automatic stall(int len, bit use_x);
    @(negedge clk);
    if (use_x) xrdy = 1'b0; else rdy = 1'b0;
    for (int c = 1; c <= len + P + 3; c++) begin
      int k = c - 1;
      bit rf = exp_rf(k, len);
      @(negedge clk);
      check(rf ? "R7" : "R6", rfsh_strobe, rf);
      check((k < len) ? "R5" : "R7", wait_n, !((k < len) || rf));
      if (c == len) begin rdy = 1'b1; xrdy = 1'b1; end
    end
  endtask

  initial begin
    rdy = 1'b0; mreq_n = 1'b0; mode = 2'b10;
    repeat (3) @(negedge clk);
    check("R9", wait_n, 1'b1);
    check("R9", rfsh_strobe, 1'b0);
    rdy = 1'b1; mreq_n = 1'b1; mode = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", wait_n, 1'b1);

    for (int md = 0; md < 4; md++) begin
      for (int f = 0; f < 2; f++) begin
        logic ew;
        ew = (md == 2) || (md == 1 && f == 1);
        mem_cycle(2'(md), 1'(f), ew);
      end
    end
    // R1: fetch marker without a memory request adds no wait
    @(negedge clk); mode = 2'b01; m1_n = 1'b0;
    @(negedge clk); check("R1", wait_n, 1'b1);
    @(negedge clk); check("R1", wait_n, 1'b1); m1_n = 1'b1;
    // R4: back-to-back accesses each give one wait
    mem_cycle(2'b10, 1'b0, 1'b1);
    mem_cycle(2'b10, 1'b0, 1'b1);
    mode = 2'b00;

    for (int len = 1; len <= 3 * (I + P) + 2; len++) stall(len, len[0]);

    // R8: two short stalls with one ready clock between
    @(negedge clk); rdy = 1'b0;
    for (int c = 1; c <= 2 * I + 6; c++) begin
      @(negedge clk);
      check("R8", rfsh_strobe, 1'b0);
      if (c == I - 1) rdy = 1'b1;
      if (c == I) rdy = 1'b0;
      if (c == 2 * I - 1) rdy = 1'b1;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule